// File: doc/BRIEF.md
# Counter Channel Interrupt Aggregator

This block merges the flag outputs of a bank of counter channels into one shared, level-active interrupt line. Each channel's flag is watched for a rising edge. When the interrupt function is armed and that channel is enabled, the edge sets a sticky pending bit. The interrupt output is active for as long as any pending bit is set. The pending bits stay set until the host issues a clear command.

The host reaches the block through a byte-wide register port at fixed offsets:

- **Offset 0x10, status (read only).** Bit n is the pending bit of channel n.
- **Offset 0x11, channel command (write only).** Takes the arm/clear and counter-reset commands.
- **Offset 0x12, channel enable (read/write).** Bit n enables channel n.

A status value of zero means this block is not requesting service, so a handler can poll it when the line is shared with other sources. The block also drives two signals to the counters:

- a "run" level that follows the armed state;
- a one-cycle reset strobe.

Top module: `cnt_irq_agg`

## Requirements
- R1: After reset the status reads 0, the enable register reads 0, `irq_o` is low, `ctr_run_o` is low, `ctr_clear_o` is low, and the interrupt function is disarmed.
- R2: A write to offset 0x12 stores the enable mask, with bit n for channel n. A read of 0x12 returns that mask combinationally.
- R3: A rising edge on `flag_i[n]` sets status bit n at the next clock edge, provided that channel n is enabled and the function is armed. A flag held high does not re-trigger.
- R4: An edge on a disabled channel, or any edge while the function is disarmed, sets no status bit.
- R5: A status bit stays set until a clear command, whatever the flag does afterwards.
- R6: `irq_o` is high exactly when the status register is nonzero. It is driven from the registered pending bits.
- R7: A write to offset 0x11 with bit 2 set and bit 0 clear (value 0x04) does three things at once: it clears every status bit, arms the function, and drives `ctr_run_o` high from the next cycle.
- R8: A write to offset 0x11 with bit 0 set (for example 0x01) disarms the function and drops `ctr_run_o`. It also pulses `ctr_clear_o` for exactly one cycle and leaves the status bits unchanged. Bit 0 takes precedence over bit 2.
- R9: An enabled edge that arrives in the same cycle as the clear command is kept: its status bit is set after the clear.
- R10: Writes to offset 0x10 have no effect. Reads of any offset other than 0x10 and 0x12 return 0.
- R11: An edge that coincides with a write to the enable register is masked by the enable value held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flag_i | input | 8 | Flag output of each counter channel, active high |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational from offset) |
| irq_o | output | 1 | Shared interrupt line, active high |
| ctr_run_o | output | 1 | Counters enabled / function armed |
| ctr_clear_o | output | 1 | One-cycle counter reset strobe |

## Verification
Two functions can fall in the same cycle: the capture of a flag edge and a write to a register. The first case is a channel flag that rises in the very cycle the clear command is written. The expected status afterwards holds only that channel's bit. The second case is an edge that coincides with a write of zero to the enable register. There the old mask must still let the bit through. A behavioural model advances on every clock, and the status, line, run and strobe outputs are compared against it on every cycle.

// File: rtl/cia_pkg.sv
package cia_pkg;
    localparam int ADDR_W = 5;
    localparam int DATA_W = 8;

    localparam logic [ADDR_W-1:0] OFS_STATUS = 5'h10;
    localparam logic [ADDR_W-1:0] OFS_CMD    = 5'h11;
    localparam logic [ADDR_W-1:0] OFS_ENABLE = 5'h12;

    localparam int CMD_RST_BIT = 0;
    localparam int CMD_ARM_BIT = 2;
endpackage

// File: rtl/cia_cmd_dec.sv
module cia_cmd_dec
    import cia_pkg::*;
#(
    parameter int NUM_CH = 8
) (
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic              ien_wr_o,
    output logic              cmd_rst_o,
    output logic              cmd_arm_o
);
    logic cmd_hit;

    always_comb begin
        cmd_hit   = we_i && (addr_i == OFS_CMD);
        ien_wr_o  = we_i && (addr_i == OFS_ENABLE);
        cmd_rst_o = cmd_hit && wdata_i[CMD_RST_BIT];
        cmd_arm_o = cmd_hit && wdata_i[CMD_ARM_BIT] && !wdata_i[CMD_RST_BIT];
    end
endmodule

// File: rtl/cia_edge_det.sv
module cia_edge_det #(
    parameter int NUM_CH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] flag_i,
    output logic [NUM_CH-1:0] rise_o
);
    logic [NUM_CH-1:0] prev_d, prev_q;

    always_comb begin
        prev_d = flag_i;
        rise_o = flag_i & ~prev_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end
endmodule

// File: rtl/cnt_irq_agg.sv
module cnt_irq_agg
    import cia_pkg::*;
#(
    parameter int NUM_CH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] flag_i,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq_o,
    output logic              ctr_run_o,
    output logic              ctr_clear_o
);
    typedef struct packed {
        logic [NUM_CH-1:0] pend;
        logic [NUM_CH-1:0] ien;
        logic              armed;
        logic              clr_pulse;
    } state_t;

    state_t state_d, state_q;

    logic              ien_wr, cmd_rst, cmd_arm;
    logic [NUM_CH-1:0] rise;
    logic              arm_eff;
    logic [NUM_CH-1:0] pend_w, ien_w;

    cia_cmd_dec #(.NUM_CH(NUM_CH)) u_dec (
        .we_i      (reg_we),
        .addr_i    (reg_addr),
        .wdata_i   (reg_wdata),
        .ien_wr_o  (ien_wr),
        .cmd_rst_o (cmd_rst),
        .cmd_arm_o (cmd_arm)
    );

    cia_edge_det #(.NUM_CH(NUM_CH)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .flag_i (flag_i),
        .rise_o (rise)
    );

    always_comb begin
        state_d = state_q;
        // an arm in this cycle already admits a coinciding edge
        arm_eff = cmd_arm || (state_q.armed && !cmd_rst);
        state_d.pend = (cmd_arm ? '0 : state_q.pend)
                     | (arm_eff ? (rise & state_q.ien) : '0);
        if (ien_wr) state_d.ien = reg_wdata[NUM_CH-1:0];
        if (cmd_arm)      state_d.armed = 1'b1;
        else if (cmd_rst) state_d.armed = 1'b0;
        state_d.clr_pulse = cmd_rst;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            OFS_STATUS: reg_rdata[NUM_CH-1:0] = state_q.pend;
            OFS_ENABLE: reg_rdata[NUM_CH-1:0] = state_q.ien;
            default:    reg_rdata = '0;
        endcase
    end

    assign pend_w      = state_q.pend;
    assign ien_w       = state_q.ien;
    assign irq_o       = |state_q.pend;
    assign ctr_run_o   = state_q.armed;
    assign ctr_clear_o = state_q.clr_pulse;
endmodule

// File: rtl/cia_chk.sv
module cia_chk
    import cia_pkg::*;
#(
    parameter int NUM_CH = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_we,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic [DATA_W-1:0] reg_rdata,
    input logic              irq_o,
    input logic              ctr_run_o,
    input logic              ctr_clear_o,
    input logic [NUM_CH-1:0] pend,
    input logic [NUM_CH-1:0] ien
);
    logic wr_arm, wr_rst;
    assign wr_arm = reg_we && reg_addr == OFS_CMD && reg_wdata[CMD_ARM_BIT] && !reg_wdata[CMD_RST_BIT];
    assign wr_rst = reg_we && reg_addr == OFS_CMD && reg_wdata[CMD_RST_BIT];

    // R5: no bit drops without the clear command
    p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_arm |=> ((pend & $past(pend)) == $past(pend)));

    // R4: new bits only on channels enabled beforehand
    p_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pend & ~$past(pend) & ~$past(ien)) == '0));

    // R4: nothing new while disarmed and not arming
    p_disarm_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctr_run_o && !wr_arm) |=> ((pend & ~$past(pend)) == '0));

    // R7: arming raises run
    p_arm_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_arm |=> ctr_run_o);

    // R8: reset command drops run and strobes clear
    p_rst_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_rst |=> (!ctr_run_o && ctr_clear_o));

    // R6: line matches a nonzero status read
    p_irq_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == OFS_STATUS) |-> ((reg_rdata != '0) == irq_o));
endmodule

bind cnt_irq_agg cia_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_we      (reg_we),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata),
    .reg_rdata   (reg_rdata),
    .irq_o       (irq_o),
    .ctr_run_o   (ctr_run_o),
    .ctr_clear_o (ctr_clear_o),
    .pend        (pend_w),
    .ien         (ien_w)
);

// File: tb/test_cnt_irq_agg.sv
`timescale 1ns/1ps
module test_cnt_irq_agg;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] flag_i = '0;
    logic       reg_we = 1'b0;
    logic [4:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       irq_o, ctr_run_o, ctr_clear_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [7:0] m_pend, m_ien, m_prev;
    logic       m_armed, m_clr;

    always #2.5 clk = ~clk;

    cnt_irq_agg #(.NUM_CH(8)) i_cnt_irq_agg (
        .clk(clk), .rst_n(rst_n), .flag_i(flag_i), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_o(irq_o), .ctr_run_o(ctr_run_o), .ctr_clear_o(ctr_clear_o)
    );

    // behavioural reference
    always @(posedge clk) begin
        logic [7:0] ev;
        bit do_rst, do_arm, live;
        if (!rst_n) begin
            m_pend = 0; m_ien = 0; m_prev = 0; m_armed = 0; m_clr = 0;
        end else begin
            ev     = flag_i & ~m_prev;
            do_rst = reg_we && reg_addr == 5'h11 && reg_wdata[0];
            do_arm = reg_we && reg_addr == 5'h11 && reg_wdata[2] && !reg_wdata[0];
            live   = do_arm || (m_armed && !do_rst);
            if (do_arm) m_pend = 0;
            if (live) m_pend = m_pend | (ev & m_ien);
            if (reg_we && reg_addr == 5'h12) m_ien = reg_wdata;
            if (do_arm) m_armed = 1; else if (do_rst) m_armed = 0;
            m_clr  = do_rst;
            m_prev = flag_i;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] m_read(input logic [4:0] a);
        if (a == 5'h10) return m_pend;
        if (a == 5'h12) return m_ien;
        return 8'h00;
    endfunction

    task automatic cycle(input logic [7:0] f, input logic we, input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        if (rst_n) begin
            chk("R6 line", {31'd0, irq_o}, {31'd0, m_pend != 0});
            chk("R7 run", {31'd0, ctr_run_o}, {31'd0, m_armed});
            chk("R8 strobe", {31'd0, ctr_clear_o}, {31'd0, m_clr});
        end
        flag_i = f; reg_we = we; reg_addr = a; reg_wdata = d;
        #1;
        if (rst_n) chk("R10 read", {24'd0, reg_rdata}, {24'd0, m_read(a)});
    endtask

    task automatic wr(input logic [7:0] f, input logic [4:0] a, input logic [7:0] d);
        cycle(f, 1'b1, a, d);
    endtask

    task automatic idle(input logic [4:0] a);
        cycle(flag_i, 1'b0, a, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        idle(5'h10);
        chk("R1 status", reg_rdata, 8'h00);
        chk("R1 irq", irq_o, 1'b0);
        chk("R1 run", ctr_run_o, 1'b0);
        idle(5'h12);
        chk("R1 enable", reg_rdata, 8'h00);
        // R2 enable write/read
        wr(8'h00, 5'h12, 8'hA5);
        idle(5'h12);
        chk("R2 enable readback", reg_rdata, 8'hA5);
        // R4 edge while disarmed
        cycle(8'h01, 1'b0, 5'h10, 8'h00);
        idle(5'h10);
        chk("R4 disarmed edge", reg_rdata, 8'h00);
        cycle(8'h00, 1'b0, 5'h10, 8'h00);
        // R7 arm
        wr(8'h00, 5'h11, 8'h04);
        idle(5'h10);
        chk("R7 run after arm", ctr_run_o, 1'b1);
        // R3 enabled edge ch0
        cycle(8'h01, 1'b0, 5'h10, 8'h00);
        idle(5'h10);
        chk("R3 ch0 set", reg_rdata, 8'h01);
        chk("R6 irq high", irq_o, 1'b1);
        // R4 disabled ch1
        cycle(8'h03, 1'b0, 5'h10, 8'h00);
        idle(5'h10);
        chk("R4 ch1 masked", reg_rdata, 8'h01);
        // R5 sticky after flags fall
        cycle(8'h00, 1'b0, 5'h10, 8'h00);
        repeat (3) idle(5'h10);
        chk("R5 sticky", reg_rdata, 8'h01);
        // R9 edge with clear in same cycle
        wr(8'h04, 5'h11, 8'h04);
        idle(5'h10);
        chk("R9 kept through clear", reg_rdata, 8'h04);
        // R11 enable write coinciding with ch5 edge
        wr(8'h24, 5'h12, 8'h00);
        idle(5'h10);
        chk("R11 old mask used", reg_rdata, 8'h24);
        // R7 clear alone
        wr(8'h00, 5'h11, 8'h04);
        idle(5'h10);
        chk("R7 cleared", reg_rdata, 8'h00);
        chk("R6 irq low", irq_o, 1'b0);
        // R10 write to status ignored, other offsets read zero
        wr(8'h00, 5'h10, 8'hFF);
        idle(5'h10);
        chk("R10 status write ignored", reg_rdata, 8'h00);
        idle(5'h03);
        chk("R10 unmapped read", reg_rdata, 8'h00);
        // R8 reset command keeps pending, disarms, strobes
        wr(8'h00, 5'h12, 8'h01);
        cycle(8'h01, 1'b0, 5'h10, 8'h00);
        cycle(8'h00, 1'b0, 5'h10, 8'h00);
        wr(8'h00, 5'h11, 8'h01);
        idle(5'h10);
        chk("R8 strobe", ctr_clear_o, 1'b1);
        chk("R8 run low", ctr_run_o, 1'b0);
        chk("R8 pending kept", reg_rdata, 8'h01);
        idle(5'h10);
        chk("R8 strobe one cycle", ctr_clear_o, 1'b0);
        // R8 precedence of bit 0 over bit 2
        wr(8'h00, 5'h11, 8'h05);
        idle(5'h10);
        chk("R8 precedence run", ctr_run_o, 1'b0);
        chk("R8 precedence pending", reg_rdata, 8'h01);
        repeat (4) idle(5'h10);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule